// File: doc/BRIEF.md
# Elliptic-Curve Factoring Second-Stage Command Sequencer

This block steers the second stage of elliptic-curve factoring. The stage runs over a set of consecutive intervals. Each interval has a bit table in which a set bit marks a precomputed point multiple that belongs to a prime. The block walks these tables one bit per clock cycle. For every position it finds, it issues a stream of opaque commands to the arithmetic side:

- load a stored multiple into point slot A or B;
- modular multiply;
- modular subtract;
- set the accumulator to one;
- the point step R ← R+Q.

The block does no arithmetic and holds no point data. It only decides which operation is issued, in which order, and on which named variables.

Found positions are taken two at a time. The pending difference r−s of the previous pair is folded into the accumulator d one round late, so only one leading pair of products is paid for the whole run. When an interval closes with one unpaired position, that position is folded at once, before R moves. After the last interval, one final difference is folded and the block raises done.

Commands leave one at a time under a valid/ready handshake. A start pulse given while idle begins a run.

Top module: `p2_cont_seq`

## Requirements
- R1: After reset, cmd_valid and done are low and every command field is zero.
- R2: Opcodes are: 1 load multiple, 2 multiply, 3 subtract, 4 point step, 5 set to one. Operand codes are: Ax 0, Az 1, Bx 2, Bz 3, Rx 4, Rz 5, r 6, s 7, t 8, u 9, d 10, d1 11, d2 12. A multiply or subtract writes dst from src_a and src_b in that order. A load writes dst 0 (slot A) or 2 (slot B) with the bit position on cmd_mult. The point step writes dst 4. Set-to-one writes dst 10. All unused fields are zero.
- R3: A run opens with the lowest set position p of interval 0, in this order: load A(p), r←Az·Rx, s←Ax·Rz, d←1.
- R4: When two more positions a then b are found in one interval, the block issues: load A(a), load B(b), t←Az·Rx, u←Ax·Rz, d1←r−s, d←d·d1, r←Bz·Rx, d2←t−u, d←d·d2, s←Bx·Rz.
- R5: When the table ends after only one further position a, the block issues load A(a), then d1←r−s, d←d·d1, r←Az·Rx, s←Ax·Rz, then the point step.
- R6: An interval whose remaining table is empty gives only the point step. After every point step the interval index moves on by one.
- R7: After the last interval's point step, the block issues d1←r−s and then d←d·d1. It then raises done and holds it with cmd_valid low.
- R8: While cmd_valid is high and cmd_ready is low, cmd_valid and all command fields stay unchanged.
- R9: A start pulse during a run has no effect on the command stream. A start pulse while idle clears done and begins a new run.
- R10: The scan examines one table bit per clock cycle, in ascending bit order and ascending interval order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| tbl_rows | input | NUM_INT*TBL_BITS | Bit tables; interval k occupies bits k*TBL_BITS upward |
| cmd_ready | input | 1 | Arithmetic side accepts the current command |
| cmd_valid | output | 1 | A command is presented |
| cmd_op | output | 3 | Opcode |
| cmd_dst | output | 4 | Destination operand code |
| cmd_src_a | output | 4 | First source operand code |
| cmd_src_b | output | 4 | Second source operand code |
| cmd_mult | output | IW | Bit position of the multiple to load |
| done | output | 1 | Run complete, held until the next start |

## Verification
The block takes for granted that interval 0 holds at least one set bit. It also takes for granted that tbl_rows stays still from start until done. The checks on handshake stability and scan stepping rely on both. The stimulus meets these terms: every table pattern in the sweep has a non-zero first interval, and the tables change only while the block is idle. The sweep varies the later intervals over empty, single, even and odd fills. It also runs each pattern with cmd_ready stalls that follow a shift-register sequence.

// File: rtl/p2_seq_pkg.sv
package p2_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_LOAD = 3'd1,
        OP_MUL  = 3'd2,
        OP_SUB  = 3'd3,
        OP_PADD = 3'd4,
        OP_SET1 = 3'd5
    } op_e;

    localparam logic [3:0] V_AX = 4'd0;
    localparam logic [3:0] V_AZ = 4'd1;
    localparam logic [3:0] V_BX = 4'd2;
    localparam logic [3:0] V_BZ = 4'd3;
    localparam logic [3:0] V_RX = 4'd4;
    localparam logic [3:0] V_RZ = 4'd5;
    localparam logic [3:0] V_R  = 4'd6;
    localparam logic [3:0] V_S  = 4'd7;
    localparam logic [3:0] V_T  = 4'd8;
    localparam logic [3:0] V_U  = 4'd9;
    localparam logic [3:0] V_D  = 4'd10;
    localparam logic [3:0] V_D1 = 4'd11;
    localparam logic [3:0] V_D2 = 4'd12;

    typedef enum logic [2:0] {
        K_INIT   = 3'd0,
        K_LDA    = 3'd1,
        K_PAIR   = 3'd2,
        K_SINGLE = 3'd3,
        K_EMPTY  = 3'd4,
        K_FINAL  = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SCAN_A = 2'd1,
        S_SCAN_B = 2'd2,
        S_ISSUE  = 2'd3
    } state_e;

    typedef struct packed {
        op_e        op;
        logic [3:0] dst;
        logic [3:0] src_a;
        logic [3:0] src_b;
    } cmd_t;

endpackage

// File: rtl/p2_row_select.sv
module p2_row_select #(
    parameter int NUM_INT  = 16,
    parameter int TBL_BITS = 24,
    parameter int MW       = 4,
    parameter int CW       = 5
) (
    input  logic [NUM_INT*TBL_BITS-1:0] tbl_rows,
    input  logic [MW-1:0]               m_sel,
    input  logic [CW-1:0]               cursor,
    output logic                        bit_set,
    output logic                        at_end
);
    logic [TBL_BITS-1:0] rows [NUM_INT];
    logic [TBL_BITS-1:0] row_sel;

    for (genvar k = 0; k < NUM_INT; k++) begin : g_row
        assign rows[k] = tbl_rows[k*TBL_BITS +: TBL_BITS];
    end

    always_comb begin
        row_sel = '0;
        for (int k = 0; k < NUM_INT; k++) begin
            if (m_sel == MW'(k)) row_sel = rows[k];
        end
    end

    always_comb begin
        bit_set = 1'b0;
        for (int j = 0; j < TBL_BITS; j++) begin
            if (cursor == CW'(j)) bit_set = row_sel[j];
        end
    end

    assign at_end = (cursor == CW'(TBL_BITS));
endmodule

// File: rtl/p2_cmd_rom.sv
module p2_cmd_rom
    import p2_seq_pkg::*;
#(
    parameter int IW = 5
) (
    input  kind_e          kind,
    input  logic [3:0]     step,
    input  logic [IW-1:0]  idx_a,
    input  logic [IW-1:0]  idx_b,
    output cmd_t           cmd,
    output logic [IW-1:0]  mult,
    output logic           last
);
    function automatic cmd_t mk(op_e op, logic [3:0] dst, logic [3:0] a, logic [3:0] b);
        cmd_t c;
        c.op = op; c.dst = dst; c.src_a = a; c.src_b = b;
        return c;
    endfunction

    always_comb begin
        cmd  = mk(OP_NONE, 4'd0, 4'd0, 4'd0);
        mult = '0;
        last = 1'b0;
        case (kind)
            K_INIT: begin
                last = (step == 4'd3);
                case (step)
                    4'd0: begin cmd = mk(OP_LOAD, V_AX, 4'd0, 4'd0); mult = idx_a; end
                    4'd1: cmd = mk(OP_MUL, V_R, V_AZ, V_RX);
                    4'd2: cmd = mk(OP_MUL, V_S, V_AX, V_RZ);
                    default: cmd = mk(OP_SET1, V_D, 4'd0, 4'd0);
                endcase
            end
            K_LDA: begin
                last = 1'b1;
                cmd  = mk(OP_LOAD, V_AX, 4'd0, 4'd0);
                mult = idx_a;
            end
            K_PAIR: begin
                last = (step == 4'd8);
                case (step)
                    4'd0: begin cmd = mk(OP_LOAD, V_BX, 4'd0, 4'd0); mult = idx_b; end
                    4'd1: cmd = mk(OP_MUL, V_T,  V_AZ, V_RX);
                    4'd2: cmd = mk(OP_MUL, V_U,  V_AX, V_RZ);
                    4'd3: cmd = mk(OP_SUB, V_D1, V_R,  V_S);
                    4'd4: cmd = mk(OP_MUL, V_D,  V_D,  V_D1);
                    4'd5: cmd = mk(OP_MUL, V_R,  V_BZ, V_RX);
                    4'd6: cmd = mk(OP_SUB, V_D2, V_T,  V_U);
                    4'd7: cmd = mk(OP_MUL, V_D,  V_D,  V_D2);
                    default: cmd = mk(OP_MUL, V_S, V_BX, V_RZ);
                endcase
            end
            K_SINGLE: begin
                last = (step == 4'd4);
                case (step)
                    4'd0: cmd = mk(OP_SUB, V_D1, V_R,  V_S);
                    4'd1: cmd = mk(OP_MUL, V_D,  V_D,  V_D1);
                    4'd2: cmd = mk(OP_MUL, V_R,  V_AZ, V_RX);
                    4'd3: cmd = mk(OP_MUL, V_S,  V_AX, V_RZ);
                    default: cmd = mk(OP_PADD, V_RX, 4'd0, 4'd0);
                endcase
            end
            K_EMPTY: begin
                last = 1'b1;
                cmd  = mk(OP_PADD, V_RX, 4'd0, 4'd0);
            end
            default: begin
                last = (step == 4'd1);
                if (step == 4'd0) cmd = mk(OP_SUB, V_D1, V_R, V_S);
                else              cmd = mk(OP_MUL, V_D,  V_D, V_D1);
            end
        endcase
    end
endmodule

// File: rtl/p2_cont_seq.sv
module p2_cont_seq
    import p2_seq_pkg::*;
#(
    parameter int NUM_INT  = 16,
    parameter int TBL_BITS = 24,
    localparam int IW = (TBL_BITS > 1) ? $clog2(TBL_BITS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NUM_INT*TBL_BITS-1:0] tbl_rows,
    input  logic                        cmd_ready,
    output logic                        cmd_valid,
    output logic [2:0]                  cmd_op,
    output logic [3:0]                  cmd_dst,
    output logic [3:0]                  cmd_src_a,
    output logic [3:0]                  cmd_src_b,
    output logic [IW-1:0]               cmd_mult,
    output logic                        done
);
    localparam int CW = $clog2(TBL_BITS + 1);
    localparam int MW = (NUM_INT > 1) ? $clog2(NUM_INT) : 1;
    localparam logic [MW-1:0] M_LAST = MW'(NUM_INT - 1);

    typedef struct packed {
        state_e        state;
        kind_e         kind;
        logic [3:0]    step;
        logic [MW-1:0] m;
        logic [CW-1:0] cursor;
        logic [IW-1:0] idx_a;
        logic [IW-1:0] idx_b;
        logic          first;
        logic          done;
    } seq_t;

    seq_t st_q, st_d;

    logic          bit_set, at_end, rom_last;
    cmd_t          rom_cmd;
    logic [IW-1:0] rom_mult;

    p2_row_select #(
        .NUM_INT(NUM_INT), .TBL_BITS(TBL_BITS), .MW(MW), .CW(CW)
    ) u_row (
        .tbl_rows(tbl_rows),
        .m_sel   (st_q.m),
        .cursor  (st_q.cursor),
        .bit_set (bit_set),
        .at_end  (at_end)
    );

    p2_cmd_rom #(.IW(IW)) u_rom (
        .kind (st_q.kind),
        .step (st_q.step),
        .idx_a(st_q.idx_a),
        .idx_b(st_q.idx_b),
        .cmd  (rom_cmd),
        .mult (rom_mult),
        .last (rom_last)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            S_IDLE: begin
                if (start) begin
                    st_d.state  = S_SCAN_A;
                    st_d.m      = '0;
                    st_d.cursor = '0;
                    st_d.first  = 1'b1;
                    st_d.done   = 1'b0;
                end
            end
            S_SCAN_A: begin
                if (at_end) begin
                    st_d.kind  = K_EMPTY;
                    st_d.step  = '0;
                    st_d.state = S_ISSUE;
                end else if (bit_set) begin
                    st_d.idx_a  = st_q.cursor[IW-1:0];
                    st_d.cursor = st_q.cursor + CW'(1);
                    st_d.kind   = st_q.first ? K_INIT : K_LDA;
                    st_d.first  = 1'b0;
                    st_d.step   = '0;
                    st_d.state  = S_ISSUE;
                end else begin
                    st_d.cursor = st_q.cursor + CW'(1);
                end
            end
            S_SCAN_B: begin
                if (at_end) begin
                    st_d.kind  = K_SINGLE;
                    st_d.step  = '0;
                    st_d.state = S_ISSUE;
                end else if (bit_set) begin
                    st_d.idx_b  = st_q.cursor[IW-1:0];
                    st_d.cursor = st_q.cursor + CW'(1);
                    st_d.kind   = K_PAIR;
                    st_d.step   = '0;
                    st_d.state  = S_ISSUE;
                end else begin
                    st_d.cursor = st_q.cursor + CW'(1);
                end
            end
            default: begin
                if (cmd_ready) begin
                    if (!rom_last) begin
                        st_d.step = st_q.step + 4'd1;
                    end else begin
                        st_d.step = '0;
                        case (st_q.kind)
                            K_INIT, K_PAIR: st_d.state = S_SCAN_A;
                            K_LDA:          st_d.state = S_SCAN_B;
                            K_SINGLE, K_EMPTY: begin
                                if (st_q.m == M_LAST) begin
                                    st_d.kind = K_FINAL;
                                end else begin
                                    st_d.m      = st_q.m + MW'(1);
                                    st_d.cursor = '0;
                                    st_d.state  = S_SCAN_A;
                                end
                            end
                            default: begin
                                st_d.state = S_IDLE;
                                st_d.done  = 1'b1;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: S_IDLE, kind: K_INIT, step: '0, m: '0, cursor: '0,
                      idx_a: '0, idx_b: '0, first: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid = (st_q.state == S_ISSUE);
    assign cmd_op    = cmd_valid ? rom_cmd.op    : 3'd0;
    assign cmd_dst   = cmd_valid ? rom_cmd.dst   : 4'd0;
    assign cmd_src_a = cmd_valid ? rom_cmd.src_a : 4'd0;
    assign cmd_src_b = cmd_valid ? rom_cmd.src_b : 4'd0;
    assign cmd_mult  = cmd_valid ? rom_mult      : '0;
    assign done      = st_q.done;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_dst)
            && $stable(cmd_src_a) && $stable(cmd_src_b) && $stable(cmd_mult)); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid); // R7

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_SCAN_A || st_q.state == S_SCAN_B) && !at_end
            |=> st_q.cursor == $past(st_q.cursor) + CW'(1)); // R10

    AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 3'd1 |-> 32'(cmd_mult) < TBL_BITS); // R2

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_op == 3'd4 && st_q.m != M_LAST
            |=> st_q.m == $past(st_q.m) + MW'(1)); // R6

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && start |=> cmd_valid); // R9
endmodule

// File: tb/sim_p2_cont_seq.sv
module sim_p2_cont_seq;
    localparam int NI = 3;
    localparam int TB = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NI*TB-1:0] tbl_rows = '0;
    logic          cmd_ready = 1'b0;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [3:0]    cmd_dst, cmd_src_a, cmd_src_b;
    logic [2:0]    cmd_mult;
    logic          done;

    int checks = 0;
    int errors = 0;
    int exp_w [0:255];
    int exp_t [0:255];
    int n_exp;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 0;

    always #4 clk = ~clk;

    p2_cont_seq #(.NUM_INT(NI), .TBL_BITS(TB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tbl_rows(tbl_rows),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
        .cmd_mult(cmd_mult), .done(done)
    );

    function automatic int pk(int op, int dst, int a, int b, int mult);
        return (op << 16) | (dst << 12) | (a << 8) | (b << 4) | mult;
    endfunction

    task automatic push(int w, int tag);
        exp_w[n_exp] = w;
        exp_t[n_exp] = tag;
        n_exp++;
    endtask

    // Reference stream, R2 encodings
    task automatic build(input logic [14:0] v);
        int cur, a, b;
        logic [4:0] row;
        n_exp = 0;
        row = v[4:0];
        a = 0;
        while (!row[a]) a++;
        // R3 opening sequence
        push(pk(1, 0, 0, 0, a), 2);
        push(pk(2, 6, 1, 4, 0), 3);
        push(pk(2, 7, 0, 5, 0), 3);
        push(pk(5, 10, 0, 0, 0), 3);
        cur = a + 1;
        for (int m = 0; m < NI; m++) begin
            row = v[m*TB +: TB];
            if (m > 0) cur = 0;
            forever begin
                a = cur;
                while (a < TB && !row[a]) a++;
                if (a == TB) begin
                    push(pk(4, 4, 0, 0, 0), 6); // R6 empty remainder
                    break;
                end
                push(pk(1, 0, 0, 0, a), 10); // R10 ascending
                b = a + 1;
                while (b < TB && !row[b]) b++;
                if (b == TB) begin
                    // R5 lone position
                    push(pk(3, 11, 6, 7, 0), 5);
                    push(pk(2, 10, 10, 11, 0), 5);
                    push(pk(2, 6, 1, 4, 0), 5);
                    push(pk(2, 7, 0, 5, 0), 5);
                    push(pk(4, 4, 0, 0, 0), 6);
                    break;
                end
                // R4 pair
                push(pk(1, 2, 0, 0, b), 4);
                push(pk(2, 8, 1, 4, 0), 4);
                push(pk(2, 9, 0, 5, 0), 4);
                push(pk(3, 11, 6, 7, 0), 4);
                push(pk(2, 10, 10, 11, 0), 4);
                push(pk(2, 6, 3, 4, 0), 4);
                push(pk(3, 12, 8, 9, 0), 4);
                push(pk(2, 10, 10, 12, 0), 4);
                push(pk(2, 7, 2, 5, 0), 4);
                cur = b + 1;
            end
        end
        // R7 closing fold
        push(pk(3, 11, 6, 7, 0), 7);
        push(pk(2, 10, 10, 11, 0), 7);
    endtask

    task automatic chk(bit ok, int tag, int act, int expv, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s act %h exp %h", tag, what, act, expv);
        end
    endtask

    task automatic run_one(input logic [14:0] v, input bit stall, input bit poke);
        int got, cyc, w;
        build(v);
        tbl_rows = v;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, 9, int'(done), 0, "done cleared by start");
        got = 0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            cmd_ready = stall ? (lfsr[0] | lfsr[1]) : 1'b1; // R8 stalls
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            start = (poke && cyc == 6); // R9 start while busy
            if (cmd_valid && cmd_ready) begin
                w = pk(int'(cmd_op), int'(cmd_dst), int'(cmd_src_a), int'(cmd_src_b), int'(cmd_mult));
                if (got < n_exp) chk(w == exp_w[got], exp_t[got], w, exp_w[got], "command");
                else chk(1'b0, 7, w, 0, "extra command");
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        cmd_ready = 1'b0;
        chk(done == 1'b1, 7, int'(done), 1, "done raised");
        chk(got == n_exp, 7, got, n_exp, "command count");
        chk(cmd_valid == 1'b0, 7, int'(cmd_valid), 0, "quiet after done");
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid == 1'b0 && done == 1'b0 && cmd_op == 3'd0 && cmd_mult == 3'd0,
            1, int'({cmd_valid, done, cmd_op}), 0, "reset state"); // R1
        run_one(15'h7FFF, 1'b0, 1'b0);
        run_one(15'h0001, 1'b0, 1'b1);
        run_one(15'h001F, 1'b1, 1'b0);
        run_one(15'h5432, 1'b1, 1'b1);
        k = 0;
        for (int v = 1; v < 32768; v += 53) begin
            if (v[4:0] != 5'd0) begin
                run_one(15'(v), k[0], k[1]);
                k++;
            end
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog act 0 exp 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule